// File: doc/BRIEF.md
# Ternary Road Pattern Matcher

This block holds a bank of track patterns. Each pattern stores one coarse bin code for each detector layer. Within an event, hits arrive as a stream of words, each carrying a layer index and a bin code. Every hit is compared against every stored pattern in the same cycle. When a stored bin matches the hit on the hit's own layer, that layer's flag for the pattern is set. The flag stays set until the event ends. A word flagged as end of event closes the event.

The comparison is ternary. Each stored layer has a small width field that tells the compare to ignore zero to three of the low bits of the bin code. One pattern can therefore cover a narrow region or a wide one. A pattern becomes a road when the number of its matched layers reaches a programmable threshold. A threshold of seven out of eight, for example, still fires a road when one layer is missing.

After the end-of-event word is accepted, the addresses of the fired patterns are sent on a valid/ready output, lowest address first. A closing marker beat follows the last road. New hits are held off until that marker has been taken. Patterns are loaded one layer at a time through a write port.

Top module: `road_finder`

## Requirements
- R1: After reset, `hit_ready` is 1 and `road_valid` is 0, and every stored bin code and width field is 0.
- R2: With a width field of 0, a hit matches a pattern layer only when all bits of the hit bin equal the stored bin.
- R3: A width field of value w (0 to 3) makes the compare ignore the w least significant bits of the bin code. All higher bits must still be equal.
- R4: A hit is compared only with the stored layer whose index equals the hit's `hit_layer` field. A bin that matches a different layer of a pattern has no effect.
- R5: Per-layer match flags are sticky within an event. Matches on one layer, from several hit words, count as one layer.
- R6: A pattern fires when its count of matched layers is greater than or equal to `road_thresh`, sampled in the cycle the end-of-event word is accepted. A threshold of 0 fires every pattern. A threshold above the layer count fires none.
- R7: Fired addresses are presented one per accepted beat, in strictly ascending order. While `road_valid` is 1 and `road_ready` is 0, `road_addr` and `road_end` hold their values.
- R8: After the last road, exactly one beat with `road_end` = 1 is sent. An event with no fired pattern produces only this beat. `road_valid` rises in the cycle after the end-of-event word is accepted.
- R9: `hit_ready` is 0 from the cycle after the end-of-event word is accepted until the `road_end` beat is accepted. It is 1 again in the next cycle.
- R10: All match flags are cleared when the end-of-event word is accepted, so the next event starts with no matched layers.
- R11: A write with `cfg_we` = 1 replaces the bin code and width field of layer `cfg_layer` of pattern `cfg_pat`. The new values are used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe of the pattern port |
| cfg_pat | input | PAT_AW | Pattern address of the write |
| cfg_layer | input | LAY_AW | Layer index of the write |
| cfg_bin | input | BIN_W | Bin code to store |
| cfg_dc | input | DC_W | Count of low bits to ignore in the compare |
| road_thresh | input | CNT_W | Matched layers needed to fire a road |
| hit_valid | input | 1 | Hit word valid |
| hit_ready | output | 1 | Block accepts hit words |
| hit_eoe | input | 1 | The word is the end-of-event marker; its layer and bin are ignored |
| hit_layer | input | LAY_AW | Layer of the hit |
| hit_bin | input | BIN_W | Coarse bin code of the hit |
| road_valid | output | 1 | Road beat valid |
| road_ready | input | 1 | Consumer takes the road beat |
| road_addr | output | PAT_AW | Address of the fired pattern (0 on the marker beat) |
| road_end | output | 1 | Marks the closing beat of the event |

## Verification
The bench builds the block with 16 patterns, 8 layers, 12-bit bin codes and 2-bit width fields. With a bank this small, every pattern can be programmed and every fired address checked in each event. The threshold-zero case then covers the full ascending scan, including the highest address, 15. With eight layers, the thresholds of seven, eight and nine can be used to check the missing-layer case, the full match, and a threshold above the layer count. Random events with randomly chosen width fields and a stalling consumer exercise the ternary compare together with output hold.

// File: rtl/rf_pkg.sv
package rf_pkg;

  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_REPORT  = 1'b1
  } rf_state_e;

  // Ternary equality: the lowest 'skip' bits take no part in the compare.
  function automatic logic ternary_eq(input logic [31:0] stored,
                                      input logic [31:0] probe,
                                      input logic [31:0] skip);
    logic [31:0] ignore;
    ignore = (32'h1 << skip) - 32'h1;
    return ((stored ^ probe) & ~ignore) == 32'h0;
  endfunction

  // Number of set flags in a vector.
  function automatic logic [31:0] flag_count(input logic [31:0] v);
    logic [31:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) n = n + {31'd0, v[i]};
    return n;
  endfunction

endpackage

// File: rtl/rf_cell.sv
module rf_cell
  import rf_pkg::*;
#(
  parameter int NL = 8,
  parameter int BW = 12,
  parameter int DW = 2,
  parameter int LW = 3,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_layer,
  input  logic [BW-1:0] wr_bin,
  input  logic [DW-1:0] wr_dc,
  input  logic          hit_en,
  input  logic [LW-1:0] hit_layer,
  input  logic [BW-1:0] hit_bin,
  input  logic          clear,
  input  logic [CW-1:0] thresh,
  output logic          fired
);

  logic [NL-1:0] lay_hit;
  logic [NL-1:0] flag_q;

  for (genvar l = 0; l < NL; l++) begin : g_lay
    logic [BW-1:0] bin_q;
    logic [DW-1:0] dc_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bin_q <= '0;
        dc_q  <= '0;
      end else if (wr_en && (wr_layer == LW'(l))) begin
        bin_q <= wr_bin;
        dc_q  <= wr_dc;
      end
    end

    assign lay_hit[l] = hit_en && (hit_layer == LW'(l)) &&
                        ternary_eq(32'(bin_q), 32'(hit_bin), 32'(dc_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= '0;
    else if (clear) flag_q <= '0;
    else            flag_q <= flag_q | lay_hit;
  end

  assign fired = flag_count(32'(flag_q)) >= 32'(thresh);

endmodule

// File: rtl/rf_pick.sv
module rf_pick #(
  parameter int N  = 64,
  parameter int AW = 6
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [AW-1:0] idx,
  output logic [N-1:0]  onehot
);

  always_comb begin
    any    = |pend;
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx       = AW'(i);
        onehot    = '0;
        onehot[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/road_finder.sv
module road_finder
  import rf_pkg::*;
#(
  parameter int NUM_PAT    = 64,
  parameter int NUM_LAYERS = 8,
  parameter int BIN_W      = 12,
  parameter int DC_W       = 2,
  localparam int PAT_AW    = $clog2(NUM_PAT),
  localparam int LAY_AW    = $clog2(NUM_LAYERS),
  localparam int CNT_W     = $clog2(NUM_LAYERS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PAT_AW-1:0] cfg_pat,
  input  logic [LAY_AW-1:0] cfg_layer,
  input  logic [BIN_W-1:0]  cfg_bin,
  input  logic [DC_W-1:0]   cfg_dc,
  input  logic [CNT_W-1:0]  road_thresh,
  input  logic              hit_valid,
  output logic              hit_ready,
  input  logic              hit_eoe,
  input  logic [LAY_AW-1:0] hit_layer,
  input  logic [BIN_W-1:0]  hit_bin,
  output logic              road_valid,
  input  logic              road_ready,
  output logic [PAT_AW-1:0] road_addr,
  output logic              road_end
);

  rf_state_e          state_q;
  logic [NUM_PAT-1:0] pend_q;
  logic [NUM_PAT-1:0] fired;
  logic [NUM_PAT-1:0] pick_oh;
  logic [PAT_AW-1:0]  pick_idx;
  logic               pick_any;

  // Named internal events, also seen by the checker.
  logic hit_take;
  logic eoe_take;
  logic road_take;

  assign hit_ready  = (state_q == ST_COLLECT);
  assign road_valid = (state_q == ST_REPORT);
  assign hit_take   = hit_valid && hit_ready && !hit_eoe;
  assign eoe_take   = hit_valid && hit_ready && hit_eoe;
  assign road_take  = road_valid && road_ready;

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    rf_cell #(
      .NL(NUM_LAYERS), .BW(BIN_W), .DW(DC_W), .LW(LAY_AW), .CW(CNT_W)
    ) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we && (cfg_pat == PAT_AW'(p))),
      .wr_layer  (cfg_layer),
      .wr_bin    (cfg_bin),
      .wr_dc     (cfg_dc),
      .hit_en    (hit_take),
      .hit_layer (hit_layer),
      .hit_bin   (hit_bin),
      .clear     (eoe_take),
      .thresh    (road_thresh),
      .fired     (fired[p])
    );
  end

  rf_pick #(.N(NUM_PAT), .AW(PAT_AW)) u_pick (
    .pend   (pend_q),
    .any    (pick_any),
    .idx    (pick_idx),
    .onehot (pick_oh)
  );

  assign road_addr = pick_any ? pick_idx : '0;
  assign road_end  = !pick_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      pend_q  <= '0;
    end else begin
      case (state_q)
        ST_COLLECT: begin
          if (eoe_take) begin
            pend_q  <= fired;
            state_q <= ST_REPORT;
          end
        end
        ST_REPORT: begin
          if (road_take) begin
            if (pick_any) pend_q  <= pend_q & ~pick_oh;
            else          state_q <= ST_COLLECT;
          end
        end
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

endmodule

// File: rtl/rf_chk.sv
module rf_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hit_ready,
  input logic          road_valid,
  input logic          road_ready,
  input logic [AW-1:0] road_addr,
  input logic          road_end,
  input logic          eoe_take,
  input logic          road_take
);

  logic          seen_q;
  logic [AW-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (road_take) begin
      seen_q <= !road_end;
      last_q <= road_addr;
    end
  end

  p_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoe_take |=> !hit_ready);

  p_reopen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (road_take && road_end) |=> (hit_ready && !road_valid));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (road_valid && !road_ready) |=>
      (road_valid && $stable(road_addr) && $stable(road_end)));

  p_ascend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && road_valid && !road_end) |-> (road_addr > last_q));

  p_report_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoe_take |=> road_valid);

endmodule

bind road_finder rf_chk #(.AW(PAT_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hit_ready  (hit_ready),
  .road_valid (road_valid),
  .road_ready (road_ready),
  .road_addr  (road_addr),
  .road_end   (road_end),
  .eoe_take   (eoe_take),
  .road_take  (road_take)
);

// File: tb/road_finder_tb.sv
module road_finder_tb;

  localparam int NP  = 16;
  localparam int NL  = 8;
  localparam int BW  = 12;
  localparam int DW  = 2;
  localparam int PAW = 4;
  localparam int LAW = 3;
  localparam int CW  = 4;

  typedef struct packed {
    logic           fin;
    logic [PAW-1:0] addr;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_we = 1'b0;
  logic [PAW-1:0] cfg_pat = '0;
  logic [LAW-1:0] cfg_layer = '0;
  logic [BW-1:0]  cfg_bin = '0;
  logic [DW-1:0]  cfg_dc = '0;
  logic [CW-1:0]  road_thresh = '0;
  logic           hit_valid = 1'b0;
  logic           hit_ready;
  logic           hit_eoe = 1'b0;
  logic [LAW-1:0] hit_layer = '0;
  logic [BW-1:0]  hit_bin = '0;
  logic           road_valid;
  logic           road_ready = 1'b1;
  logic [PAW-1:0] road_addr;
  logic           road_end;

  always #10 clk = ~clk;

  road_finder #(.NUM_PAT(NP), .NUM_LAYERS(NL), .BIN_W(BW), .DC_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pat(cfg_pat),
    .cfg_layer(cfg_layer), .cfg_bin(cfg_bin), .cfg_dc(cfg_dc),
    .road_thresh(road_thresh), .hit_valid(hit_valid), .hit_ready(hit_ready),
    .hit_eoe(hit_eoe), .hit_layer(hit_layer), .hit_bin(hit_bin),
    .road_valid(road_valid), .road_ready(road_ready), .road_addr(road_addr),
    .road_end(road_end)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    stall_mode = 1'b0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  int   m_bin [NP][NL];
  int   m_dc  [NP][NL];
  int   ev_l[$];
  int   ev_b[$];
  exp_t exp_q[$];

  task automatic note(input bit ok, input string req, input string what,
                      input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic program_cell(input int p, input int l, input int b, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pat = PAW'(p); cfg_layer = LAW'(l);
    cfg_bin = BW'(b); cfg_dc = DW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    m_bin[p][l] = b;
    m_dc[p][l]  = d;
  endtask

  task automatic send_hit(input int l, input int b);
    ev_l.push_back(l);
    ev_b.push_back(b & ((1 << BW) - 1));
    @(negedge clk);
    hit_valid = 1'b1; hit_eoe = 1'b0;
    hit_layer = LAW'(l); hit_bin = BW'(b);
    while (!hit_ready) @(negedge clk);
    @(negedge clk);
    hit_valid = 1'b0;
  endtask

  // Matched layers of pattern p: equal after dropping the ignored low bits.
  function automatic int layers_hit(input int p);
    int cnt = 0;
    for (int l = 0; l < NL; l++) begin
      bit got = 1'b0;
      for (int i = 0; i < ev_l.size(); i++)
        if (ev_l[i] == l && (ev_b[i] >> m_dc[p][l]) == (m_bin[p][l] >> m_dc[p][l]))
          got = 1'b1;
      if (got) cnt++;
    end
    return cnt;
  endfunction

  task automatic end_event(input int thr, input string req);
    exp_t e;
    @(negedge clk);
    cur_req = req;
    road_thresh = CW'(thr);
    for (int p = 0; p < NP; p++) begin
      if (layers_hit(p) >= thr) begin
        e.fin = 1'b0; e.addr = PAW'(p);
        exp_q.push_back(e);
      end
    end
    e.fin = 1'b1; e.addr = '0;
    exp_q.push_back(e);
    ev_l.delete();
    ev_b.delete();
    hit_valid = 1'b1; hit_eoe = 1'b1;
    while (!hit_ready) @(negedge clk);
    @(negedge clk);
    hit_valid = 1'b0; hit_eoe = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    note(hit_ready == 1'b1, "R9", "hit_ready after end beat", int'(hit_ready), 1);
  endtask

  // Consumer ready, changed well after the rising edge.
  always @(posedge clk) begin
    #2;
    road_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  // Monitor: pops the expected beats and compares them at the falling edge.
  logic           p_stall = 1'b0;
  logic [PAW-1:0] p_addr = '0;
  logic           p_end = 1'b0;

  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && !finished) begin
      if (road_valid) begin
        note(!hit_ready, "R9", "hit_ready during report", int'(hit_ready), 0);
        if (p_stall)
          note(road_addr == p_addr && road_end == p_end, "R7", "held beat",
               int'(road_addr), int'(p_addr));
        if (road_ready) begin
          if (exp_q.size() == 0) begin
            note(1'b0, cur_req, "unexpected road beat", int'(road_addr), -1);
          end else begin
            e = exp_q.pop_front();
            note(road_end == e.fin, cur_req, "end flag", int'(road_end), int'(e.fin));
            if (!e.fin)
              note(road_addr == e.addr, cur_req, "road address",
                   int'(road_addr), int'(e.addr));
          end
        end
      end
      p_stall = road_valid && !road_ready;
      p_addr  = road_addr;
      p_end   = road_end;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R8 watchdog expired: actual %0d expected %0d", 0, 1);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    for (int p = 0; p < NP; p++)
      for (int l = 0; l < NL; l++) begin
        m_bin[p][l] = 0; m_dc[p][l] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    note(hit_ready == 1'b1, "R1", "hit_ready after reset", int'(hit_ready), 1);
    note(road_valid == 1'b0, "R1", "road_valid after reset", int'(road_valid), 0);

    // R1: storage is zero, so bin 0 on every layer fires all patterns.
    for (int l = 0; l < NL; l++) send_hit(l, 0);
    end_event(8, "R1");

    for (int p = 0; p < NP; p++)
      for (int l = 0; l < NL; l++) program_cell(p, l, (p << 5) | (l << 2), 0);

    // R2: exact match, then a single low-bit difference.
    for (int l = 0; l < NL; l++) send_hit(l, m_bin[3][l]);
    end_event(8, "R2");
    for (int l = 0; l < NL; l++) send_hit(l, (l == 6) ? m_bin[4][l] ^ 1 : m_bin[4][l]);
    end_event(8, "R2");

    // R6: one layer missing, threshold 8, 7 and 9.
    for (int l = 1; l < NL; l++) send_hit(l, m_bin[5][l]);
    end_event(8, "R6");
    for (int l = 1; l < NL; l++) send_hit(l, m_bin[5][l]);
    end_event(7, "R6");
    for (int l = 0; l < NL; l++) send_hit(l, m_bin[5][l]);
    end_event(9, "R6");

    // R3: width field masks low bits.
    program_cell(9, 0, m_bin[9][0], 2);
    send_hit(0, m_bin[9][0] ^ 3);
    end_event(1, "R3");
    send_hit(0, m_bin[9][0] ^ 4);
    end_event(1, "R3");
    program_cell(9, 0, m_bin[9][0], 3);
    send_hit(0, m_bin[9][0] ^ 7);
    end_event(1, "R3");

    // R11: rewritten bin replaces the old one.
    program_cell(12, 2, 12'hABC, 0);
    send_hit(2, 12'hABC);
    end_event(1, "R11");
    send_hit(2, (12 << 5) | (2 << 2));
    end_event(1, "R11");

    // R4: a bin of layer 3 presented on layer 4.
    send_hit(4, m_bin[2][3]);
    end_event(1, "R4");

    // R5: repeated layer counts once; scattered layers accumulate.
    send_hit(1, m_bin[7][1]);
    send_hit(1, m_bin[7][1]);
    end_event(2, "R5");
    send_hit(0, m_bin[7][0]);
    send_hit(5, m_bin[1][5]);
    send_hit(1, m_bin[7][1]);
    end_event(2, "R5");

    // R10: after a full match, an empty event fires nothing.
    for (int l = 0; l < NL; l++) send_hit(l, m_bin[6][l]);
    end_event(8, "R10");
    end_event(1, "R10");

    // R7 and R8: every pattern fires under a stalling consumer.
    stall_mode = 1'b1;
    end_event(0, "R7");
    end_event(NL + 1, "R8");

    // Random width fields and events.
    for (int p = 0; p < NP; p++)
      for (int l = 0; l < NL; l++) program_cell(p, l, m_bin[p][l], int'($urandom % 4));
    for (int ev = 0; ev < 20; ev++) begin
      int p = int'($urandom % NP);
      for (int l = 0; l < NL; l++)
        if (($urandom % 6) != 0) send_hit(l, m_bin[p][l] ^ int'($urandom % 8));
      end_event(5 + int'($urandom % 4), "R6");
    end

    note(exp_q.size() == 0, "R8", "beats left unseen", exp_q.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule